// File: doc/BRIEF.md
# Exhaustive Shortest Closed Tour Finder

This block computes the length of the shortest closed tour over `NC` cities. It tries every ordering of the cities and keeps the best one. A run begins with a one-cycle `start` in the idle phase. The block then takes the whole distance table through a valid/ready input, one 16-bit word per transfer, and stores each word in four identical table copies at the same time.

Once the table is loaded, four evaluation lanes score four consecutive permutation indices on every clock cycle. Each lane:

- turns its index into a city ordering,
- sums the edge lengths of that ordering into a tour length,
- keeps its own running minimum.

When every index has been tried, a reduction stage picks the smallest of the four lane minima. It presents that value on `best_len` together with a one-cycle `done`.

Back-pressure: `in_ready` is high only during the load phase. A word moves only in a cycle where both `in_valid` and `in_ready` are high. The source may insert idle cycles between words. It may also leave `in_valid` high at any other time; outside the load phase that has no effect.

Top module: `tour_search`

## Requirements
- R1: After reset, `in_ready` is 0, `done` is 0 and `best_len` is 0.
- R2: `start` is taken only in the idle phase. `in_ready` then stays high until exactly `NC*NC` words have transferred (each a cycle with `in_valid` and `in_ready` both high, gaps allowed), and goes low in the cycle after the last one. Words offered while `in_ready` is low are ignored and do not shift the load position.
- R3: The transfer with zero-based number i carries the distance from city i/NC to city i%NC. Distances are directional: entry (a,b) is used only for the hop from a to b.
- R4: A tour starts at city 0, visits every other city exactly once and returns to city 0. Its length is the sum of the distances of all its hops, including the closing hop.
- R5: `best_len` equals the minimum tour length over all (NC-1)! orderings. It is `DW+clog2(NC)` bits wide, so a table filled with 0xFFFF gives NC*65535 without wrap-around.
- R6: When (NC-1)! is not a multiple of four, lane indices at or above (NC-1)! in the last group do not affect the result.
- R7: `done` is high for exactly one cycle, and `best_len` holds the valid result in that cycle and afterwards.
- R8: The search takes a new group of four indices every cycle. `done` rises exactly ceil((NC-1)!/4)+2 cycles after the edge that accepts the last table word.
- R9: A `start` that is high during the search, the reduction or the `done` cycle itself is ignored, so the block is idle with `in_ready` low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when seen in the idle phase |
| in_valid | input | 1 | Distance word offered |
| in_ready | output | 1 | Block accepts a distance word (load phase only) |
| in_data | input | DW | Distance word, unsigned |
| done | output | 1 | One-cycle pulse: `best_len` is valid |
| best_len | output | DW+clog2(NC) | Shortest tour length of the last run |

## Verification
The `start` request can coincide with the `done` pulse. The bench holds `start` high from the last table word through the `done` cycle. It then checks that `in_ready` is still low in the following cycle, which shows that the block went back to idle and did not begin a new load. A second overlap is the final lane group: its out-of-range indices are evaluated in the same cycle as valid ones. The bench builds a table in which the decoded out-of-range orderings would be far shorter than any real tour. A correct result therefore shows that those lanes were masked.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_SEARCH, PH_FLUSH, PH_REDUCE, PH_DONE
  } phase_t;

  function automatic int fact(input int n);
    int f;
    f = 1;
    for (int k = 2; k <= n; k++) f = f * k;
    return f;
  endfunction

endpackage

// File: rtl/dist_bank.sv
module dist_bank #(
  parameter int NC = 5,
  parameter int DW = 16,
  localparam int NN = NC * NC,
  localparam int AW = $clog2(NN)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  output logic [NN*DW-1:0] tbl
);

  logic [DW-1:0] mem [NN];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar e = 0; e < NN; e++) begin : g_rd
    assign tbl[e*DW +: DW] = mem[e];
  end

endmodule

// File: rtl/tour_lane.sv
module tour_lane import tsp_pkg::*; #(
  parameter int NC = 5,
  parameter int DW = 16,
  parameter int IW = 8,
  localparam int NN = NC * NC,
  localparam int M  = NC - 1,
  localparam int TOTAL = fact(NC - 1),
  localparam int LW = DW + $clog2(NC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             issue,
  input  logic [IW-1:0]    idx,
  input  logic [NN*DW-1:0] tbl,
  output logic [LW-1:0]    cand
);

  logic [LW-1:0] tour_len, len_q;
  logic          vld_q;

  // Lehmer-code decode of idx, then sum of the hop distances.
  always_comb begin
    logic [NC-1:0] used;
    int route [NC];
    int r, dig, cnt, pick;
    used     = '0;
    r        = int'(idx);
    route[0] = 0;
    tour_len = '0;
    for (int p = 0; p < M; p++) begin
      dig  = r / fact(M - 1 - p);
      r    = r % fact(M - 1 - p);
      pick = 0;
      cnt  = 0;
      for (int c = 1; c < NC; c++) begin
        if (!used[c]) begin
          if (cnt == dig) pick = c;
          cnt++;
        end
      end
      used[pick]   = 1'b1;
      route[p + 1] = pick;
    end
    for (int p = 0; p < NC; p++) begin
      tour_len = tour_len +
        LW'(tbl[(route[p] * NC + route[(p + 1) % NC]) * DW +: DW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      len_q <= '0;
      cand  <= '1;
    end else if (clr) begin
      vld_q <= 1'b0;
      cand  <= '1;
    end else begin
      vld_q <= issue && (idx < IW'(TOTAL));
      len_q <= tour_len;
      if (vld_q && len_q < cand) cand <= len_q;
    end
  end

  // R5
  cand_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cand <= $past(cand));

  // R6
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !vld_q) |=> $stable(cand));

endmodule

// File: rtl/min_reduce.sv
module min_reduce #(
  parameter int LANES = 4,
  parameter int LW    = 18
) (
  input  logic [LANES*LW-1:0] vals,
  output logic [LW-1:0]       low
);

  always_comb begin
    low = vals[LW-1:0];
    for (int k = 1; k < LANES; k++) begin
      if (vals[k*LW +: LW] < low) low = vals[k*LW +: LW];
    end
  end

endmodule

// File: rtl/tour_search.sv
module tour_search import tsp_pkg::*; #(
  parameter int NC    = 5,
  parameter int DW    = 16,
  parameter int LANES = 4,
  localparam int NN    = NC * NC,
  localparam int AW    = $clog2(NN),
  localparam int TOTAL = fact(NC - 1),
  localparam int IW    = $clog2(TOTAL + LANES) + 1,
  localparam int LW    = DW + $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          done,
  output logic [LW-1:0] best_len
);

  phase_t             ph;
  logic [AW-1:0]      ld_cnt;
  logic [IW-1:0]      base;
  logic               clr, issue, wr_en, last_grp;
  logic [LANES*LW-1:0] cand_w;
  logic [LW-1:0]      red_min;

  assign in_ready = (ph == PH_LOAD);
  assign wr_en    = in_valid && in_ready;
  assign clr      = (ph == PH_IDLE) && start;
  assign issue    = (ph == PH_SEARCH);
  assign last_grp = (base + IW'(LANES)) >= IW'(TOTAL);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [NN*DW-1:0] tbl;

    dist_bank #(.NC(NC), .DW(DW)) u_bank (
      .clk(clk), .we(wr_en), .waddr(ld_cnt), .wdata(in_data), .tbl(tbl)
    );

    tour_lane #(.NC(NC), .DW(DW), .IW(IW)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(clr), .issue(issue),
      .idx(base + IW'(k)), .tbl(tbl), .cand(cand_w[k*LW +: LW])
    );

    // R5
    reduce_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> best_len <= cand_w[k*LW +: LW]);
  end

  min_reduce #(.LANES(LANES), .LW(LW)) u_red (.vals(cand_w), .low(red_min));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      ld_cnt   <= '0;
      base     <= '0;
      done     <= 1'b0;
      best_len <= '0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_LOAD;
          ld_cnt <= '0;
        end
        PH_LOAD: if (in_valid) begin
          if (ld_cnt == AW'(NN - 1)) begin
            ph   <= PH_SEARCH;
            base <= '0;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        PH_SEARCH: begin
          base <= base + IW'(LANES);
          if (last_grp) ph <= PH_FLUSH;
        end
        PH_FLUSH:  ph <= PH_REDUCE;
        PH_REDUCE: begin
          best_len <= red_min;
          done     <= 1'b1;
          ph       <= PH_DONE;
        end
        PH_DONE:   ph <= PH_IDLE;
        default:   ph <= PH_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ld_cnt == AW'(NN - 1)) |=> !in_ready);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !in_ready);

endmodule

// File: tb/sim_tour_search.sv
module sim_tour_search;

  localparam int NC = 4;
  localparam int LW = 16 + $clog2(NC);
  localparam int EXP_LAT = 4;  // ceil(3!/4) + 2

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, done;
  logic [LW-1:0] best_len;

  int nchk = 0, nfail = 0, cyc = 0;
  int tab [16];
  int got_best, got_lat;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tour_search #(.NC(NC), .DW(16), .LANES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .done(done), .best_len(best_len)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ref_best();
    int b, t;
    b = 32'h7fffffff;
    for (int a = 1; a < 4; a++)
      for (int m = 1; m < 4; m++)
        for (int c = 1; c < 4; c++)
          if (a != m && m != c && a != c) begin
            t = tab[a] + tab[a*4+m] + tab[m*4+c] + tab[c*4];
            if (t < b) b = t;
          end
    return b;
  endfunction

  // One complete run: start, load tab, wait for done.
  task automatic run_load(input bit gaps, input bit hold_start);
    int i, lastc, dc;
    bit gapped;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 in_ready high in load", in_ready, 1);
    i = 0; gapped = 1'b0; lastc = 0;
    while (i < 16) begin
      if (gaps && !gapped && (i % 3 == 1)) begin
        in_valid = 1'b0; gapped = 1'b1;
      end else begin
        in_valid = 1'b1; in_data = tab[i][15:0]; gapped = 1'b0;
        if (in_ready) begin i++; lastc = cyc + 1; end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    start = hold_start;
    chk("R2 in_ready low after last word", in_ready, 0);
    dc = -1;
    for (int w = 0; w < 60; w++) begin
      if (done) begin dc = cyc; break; end
      @(negedge clk);
    end
    got_lat  = dc - lastc;
    got_best = int'(best_len);
    @(negedge clk);
    chk("R7 done lasts one cycle", done, 0);
    chk("R7 best_len held after done", best_len, got_best);
    if (hold_start) begin
      start = 1'b0;
      chk("R9 start during done ignored, in_ready", in_ready, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset in_ready", in_ready, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset best_len", best_len, 0);
  endtask

  task automatic t_random();
    int unsigned s;
    s = 32'h1234;
    for (int i = 0; i < 16; i++) begin
      s = s * 1103515245 + 12345;
      tab[i] = int'((s >> 8) % 5000);
    end
    run_load(1'b0, 1'b0);
    chk("R4 R5 random table result", got_best, ref_best());
    chk("R8 latency after last word", got_lat, EXP_LAT);
  endtask

  task automatic t_asym_gaps();
    // R3: directed weights; reverse hops are expensive
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        tab[r*4+c] = (c == (r + 1) % 4) ? 7 + r : 900 + 13*r + c;
    run_load(1'b1, 1'b0);
    chk("R3 directed table with gaps", got_best, ref_best());
    chk("R3 shortest is 0-1-2-3-0", got_best, 7 + 8 + 9 + 10);
    chk("R8 latency with gapped load", got_lat, EXP_LAT);
  endtask

  task automatic t_tail();
    // R6: out-of-range orders would reuse city 0 with zero diagonal
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        tab[r*4+c] = (r == c) ? 0 : ((r == 3 || c == 3) ? 1000 : 10);
    run_load(1'b0, 1'b0);
    chk("R6 tail lanes masked", got_best, 2020);
  endtask

  task automatic t_max();
    for (int i = 0; i < 16; i++) tab[i] = 65535;
    run_load(1'b0, 1'b0);
    chk("R5 all-max table no wrap", got_best, 4 * 65535);
  endtask

  task automatic t_junk();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 16'h0001;
      chk("R2 in_ready low while idle", in_ready, 0);
    end
    @(negedge clk); in_valid = 1'b0;
    for (int i = 0; i < 16; i++) tab[i] = 100 + 3 * i;
    run_load(1'b0, 1'b0);
    chk("R2 idle words ignored", got_best, ref_best());
  endtask

  task automatic t_start_done();
    for (int i = 0; i < 16; i++) tab[i] = 40 + ((i * 7) % 11);
    run_load(1'b0, 1'b1);
    chk("R9 result with start held", got_best, ref_best());
  endtask

  initial begin
    #1_600_000;
    nfail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_asym_gaps();
    t_tail();
    t_max();
    t_junk();
    t_start_done();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule